// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers completion and error events from a bank of DMA channels and folds them onto a small set of level-sensitive interrupt lines. Each channel keeps a register of event flags that records every event it receives. Each channel also has an event-enable register that decides which of those events may raise an interrupt.

Every interrupt line has its own status bitmap and its own enable bitmap, with one bit per channel. An enabled event on a channel marks that channel's bit in the status bitmap of every line. Each line then raises its output when any marked channel is also enabled for that line. Software can route one channel to several processors this way and acknowledge it on each line on its own.

All status registers clear when software writes ones to them. A single-port register interface gives access to every register. Reads return data one cycle after the read strobe.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset, every channel flag register, channel enable register, line status bitmap and line enable bitmap reads zero, and all interrupt outputs are low.
- R2: A one-cycle pulse on a channel's event input at flag position f (1 to 12) sets bit f of that channel's flag register on the next edge, whatever the channel's enable holds. Pulses at position 0 are ignored, and bit 0 always reads zero.
- R3: A write to a channel flag register clears exactly the flags whose mask bits are 1. A mask of 0x1FFE clears every flag.
- R4: A channel enable register stores bits 1 to 12 of the written value and reads bit 0 as zero. An event whose flag bit is 0 in the enable leaves every line status bitmap unchanged, so an enable of zero masks the channel completely.
- R5: An event whose flag is enabled on channel c sets bit c in the status bitmap of every line on the next edge.
- R6: Writing a line status bitmap clears the channel bits written as 1. The other bits of that line and all other lines stay unchanged.
- R7: Interrupt output l is a registered level equal to the OR of (status AND enable) of line l. It rises one cycle after that product becomes nonzero and falls one cycle after it becomes zero.
- R8: When an event and a clearing write hit the same flag bit or the same line status bit in the same cycle, the bit ends set.
- R9: Each line enable bitmap stores all 32 written bits independently of the other lines.
- R10: Register map (8-bit word address): line status l at 0x00+l, line enable l at 0x04+l, channel flags c at 0x40+c, channel enable c at 0x80+c. Unmapped addresses read zero. reg_rdata changes only in the cycle after reg_re is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 416 | Event pulses; channel c flag f at bit c*13+f |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_re |
| irq_o | output | 4 | Level interrupt outputs, one per line |

## Verification
The bench builds the block with its default parameters: 32 channels, four lines and a 13-bit flag field. With these values the outermost channel (bit 31 of every bitmap), the highest flag (position 12) and the last line are all reachable. It can therefore check that channel 31 routes to line 3 with no truncation and that the reserved flag position 0 stays dead. Because four lines share one channel set, the bench can show that one event marks all lines while per-line enables and per-line acknowledgements stay independent.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    localparam int AW     = 8;
    localparam int DW     = 32;
    localparam int FLAG_W = 13;

    // Flag positions inside a channel flag register; position 0 is reserved
    localparam int FLG_SYNC_DROP = 1;
    localparam int FLG_HALF      = 2;
    localparam int FLG_FRAME     = 3;
    localparam int FLG_LAST      = 4;
    localparam int FLG_BLOCK     = 5;
    localparam int FLG_SYNC      = 6;
    localparam int FLG_PKT_END   = 7;
    localparam int FLG_XFER_ERR  = 8;
    localparam int FLG_SEC_ERR   = 9;
    localparam int FLG_SUPV_ERR  = 10;
    localparam int FLG_ALIGN_ERR = 11;
    localparam int FLG_DRAIN     = 12;

    localparam logic [FLAG_W-1:0] FLAG_VALID = 13'h1FFE;

    // Region base addresses (word addressed)
    localparam logic [AW-1:0] BASE_LSTAT = 8'h00;
    localparam logic [AW-1:0] BASE_LEN   = 8'h04;
    localparam logic [AW-1:0] BASE_CSTAT = 8'h40;
    localparam logic [AW-1:0] BASE_CEN   = 8'h80;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_LSTAT,
        RG_LEN,
        RG_CSTAT,
        RG_CEN
    } region_e;
endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
    import dmairq_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int NUM_LINES = 4
) (
    input  logic [AW-1:0]        addr_i,
    output logic [NUM_CH-1:0]    cstat_hit_o,
    output logic [NUM_CH-1:0]    cen_hit_o,
    output logic [NUM_LINES-1:0] lstat_hit_o,
    output logic [NUM_LINES-1:0] len_hit_o
);
    localparam logic [AW-1:0] END_LSTAT = BASE_LSTAT + AW'(NUM_LINES);
    localparam logic [AW-1:0] END_LEN   = BASE_LEN   + AW'(NUM_LINES);
    localparam logic [AW-1:0] END_CSTAT = BASE_CSTAT + AW'(NUM_CH);
    localparam logic [AW-1:0] END_CEN   = BASE_CEN   + AW'(NUM_CH);

    region_e       region;
    logic [AW-1:0] offset;

    always_comb begin
        region = RG_NONE;
        offset = '0;
        if (addr_i >= BASE_LSTAT && addr_i < END_LSTAT) begin
            region = RG_LSTAT;
            offset = addr_i - BASE_LSTAT;
        end else if (addr_i >= BASE_LEN && addr_i < END_LEN) begin
            region = RG_LEN;
            offset = addr_i - BASE_LEN;
        end else if (addr_i >= BASE_CSTAT && addr_i < END_CSTAT) begin
            region = RG_CSTAT;
            offset = addr_i - BASE_CSTAT;
        end else if (addr_i >= BASE_CEN && addr_i < END_CEN) begin
            region = RG_CEN;
            offset = addr_i - BASE_CEN;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_hit
        assign cstat_hit_o[c] = (region == RG_CSTAT) && (offset == AW'(c));
        assign cen_hit_o[c]   = (region == RG_CEN)   && (offset == AW'(c));
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_ln_hit
        assign lstat_hit_o[l] = (region == RG_LSTAT) && (offset == AW'(l));
        assign len_hit_o[l]   = (region == RG_LEN)   && (offset == AW'(l));
    end
endmodule

// File: rtl/dmairq_chan_slice.sv
module dmairq_chan_slice
    import dmairq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] evt_i,
    input  logic              stat_we_i,
    input  logic              en_we_i,
    input  logic [FLAG_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] stat_o,
    output logic [FLAG_W-1:0] en_o,
    output logic              hit_o
);
    logic [FLAG_W-1:0] stat_q;
    logic [FLAG_W-1:0] en_q;
    logic [FLAG_W-1:0] evt_valid;
    logic [FLAG_W-1:0] clr_mask;

    assign evt_valid = evt_i & FLAG_VALID;
    assign clr_mask  = stat_we_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | evt_valid;
            if (en_we_i) begin
                en_q <= wdata_i & FLAG_VALID;
            end
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign hit_o  = |(evt_valid & en_q);

    AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_valid) |=> ((stat_q & $past(evt_valid)) == $past(evt_valid))); // R2
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we_i && !(|evt_i)) |=> ((stat_q & $past(wdata_i) & FLAG_VALID) == '0)); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_we_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8
endmodule

// File: rtl/dmairq_line_slice.sv
module dmairq_line_slice #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              stat_we_i,
    input  logic              en_we_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] stat_o,
    output logic [NUM_CH-1:0] en_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] stat_q;
    logic [NUM_CH-1:0] en_q;
    logic              irq_q;
    logic [NUM_CH-1:0] clr_mask;

    assign clr_mask = stat_we_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | set_i;
            if (en_we_i) begin
                en_q <= wdata_i;
            end
            irq_q <= |(stat_q & en_q);
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign irq_o  = irq_q;

    AST_LINE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R5
    AST_LINE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_we_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(en_q != '0)); // R7
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past((stat_q & en_q) == '0)); // R7
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dmairq_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int NUM_LINES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*FLAG_W-1:0] evt_i,
    input  logic                     reg_we,
    input  logic                     reg_re,
    input  logic [AW-1:0]            reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    output logic [DW-1:0]            reg_rdata,
    output logic [NUM_LINES-1:0]     irq_o
);
    logic [NUM_CH-1:0]    cstat_hit;
    logic [NUM_CH-1:0]    cen_hit;
    logic [NUM_LINES-1:0] lstat_hit;
    logic [NUM_LINES-1:0] len_hit;

    logic [FLAG_W-1:0] ch_stat [NUM_CH];
    logic [FLAG_W-1:0] ch_en   [NUM_CH];
    logic [NUM_CH-1:0] ch_hit;
    logic [NUM_CH-1:0] ln_stat [NUM_LINES];
    logic [NUM_CH-1:0] ln_en   [NUM_LINES];

    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;

    dmairq_decode #(
        .NUM_CH   (NUM_CH),
        .NUM_LINES(NUM_LINES)
    ) u_decode (
        .addr_i     (reg_addr),
        .cstat_hit_o(cstat_hit),
        .cen_hit_o  (cen_hit),
        .lstat_hit_o(lstat_hit),
        .len_hit_o  (len_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dmairq_chan_slice u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[c*FLAG_W +: FLAG_W]),
            .stat_we_i(reg_we && cstat_hit[c]),
            .en_we_i  (reg_we && cen_hit[c]),
            .wdata_i  (reg_wdata[FLAG_W-1:0]),
            .stat_o   (ch_stat[c]),
            .en_o     (ch_en[c]),
            .hit_o    (ch_hit[c])
        );
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        dmairq_line_slice #(
            .NUM_CH(NUM_CH)
        ) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (ch_hit),
            .stat_we_i(reg_we && lstat_hit[l]),
            .en_we_i  (reg_we && len_hit[l]),
            .wdata_i  (reg_wdata[NUM_CH-1:0]),
            .stat_o   (ln_stat[l]),
            .en_o     (ln_en[l]),
            .irq_o    (irq_o[l])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (cstat_hit[c]) rd_mux = rd_mux | DW'(ch_stat[c]);
            if (cen_hit[c])   rd_mux = rd_mux | DW'(ch_en[c]);
        end
        for (int l = 0; l < NUM_LINES; l++) begin
            if (lstat_hit[l]) rd_mux = rd_mux | DW'(ln_stat[l]);
            if (len_hit[l])   rd_mux = rd_mux | DW'(ln_en[l]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_re) begin
            rdata_q <= rd_mux;
        end
    end

    assign reg_rdata = rdata_q;

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_re) |=> $stable(reg_rdata)); // R10
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cstat_hit, cen_hit, lstat_hit, len_hit})); // R10
endmodule

// File: tb/sim_dma_irq_aggregator.sv
module sim_dma_irq_aggregator;
    localparam int NCH = 32;
    localparam int NLN = 4;
    localparam int FW  = 13;
    localparam logic [7:0] A_LSTAT = 8'h00;
    localparam logic [7:0] A_LEN   = 8'h04;
    localparam logic [7:0] A_CSTAT = 8'h40;
    localparam logic [7:0] A_CEN   = 8'h80;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH*FW-1:0] evt_i;
    logic             reg_we, reg_re;
    logic [7:0]       reg_addr;
    logic [31:0]      reg_wdata;
    logic [31:0]      reg_rdata;
    logic [NLN-1:0]   irq_o;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;
    logic chk_req = 1'b0;
    logic chk_seen = 1'b0;

    bit          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    dma_irq_aggregator u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_o    (irq_o)
    );

    always @(posedge clk) chk_seen <= chk_req;

    // Monitor: pops one expected item per requested observation
    always @(negedge clk) begin
        if (chk_seen) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard empty got=%h exp=none", reg_rdata);
            end else begin
                automatic bit          k = kind_q.pop_front();
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                automatic logic [31:0] g = k ? {28'b0, irq_o} : reg_rdata;
                checks++;
                if (g !== e) begin
                    fails++;
                    $display("FAIL %s got=%h exp=%h", t, g, e);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        evt_i   = '0;
        reg_we  = 1'b0;
        reg_re  = 1'b0;
        chk_req = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
    endtask

    task automatic pulse(input int ch, input int f);
        evt_i[ch*FW+f] = 1'b1;
        cyc();
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        reg_re = 1'b1; reg_addr = a; chk_req = 1'b1;
        kind_q.push_back(1'b0); exp_q.push_back(e); tag_q.push_back(t);
        cyc();
    endtask

    task automatic exp_irq(input logic [3:0] e, input string t);
        chk_req = 1'b1;
        kind_q.push_back(1'b1); exp_q.push_back({28'b0, e}); tag_q.push_back(t);
        cyc();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=timeout exp=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; evt_i = '0; reg_we = 1'b0; reg_re = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        exp_rd(A_LSTAT + 8'd0, 32'h0, "R1 line0 status");
        exp_rd(A_LEN + 8'd3, 32'h0, "R1 line3 enable");
        exp_rd(A_CSTAT + 8'd0, 32'h0, "R1 ch0 flags");
        exp_rd(A_CEN + 8'd31, 32'h0, "R1 ch31 enable");
        exp_irq(4'b0000, "R1 irq low");

        // Flag recorded with enable zero; lines untouched
        pulse(5, 3);
        exp_rd(A_CSTAT + 8'd5, 32'h8, "R2 ch5 frame flag");
        exp_rd(A_LSTAT + 8'd0, 32'h0, "R4 zero enable masks line");
        exp_irq(4'b0000, "R4 no irq when masked");

        // Channel enable storage
        wr(A_CEN + 8'd5, 32'h0000_FFFF);
        exp_rd(A_CEN + 8'd5, 32'h1FFE, "R4 enable bit0 reads zero");

        // Line enables
        wr(A_LEN + 8'd0, 32'h0000_0020);
        wr(A_LEN + 8'd1, 32'h0000_0F00);
        wr(A_LEN + 8'd2, 32'hFFFF_FFFF);
        exp_rd(A_LEN + 8'd1, 32'h0000_0F00, "R9 line1 enable");
        exp_rd(A_LEN + 8'd3, 32'h0, "R9 line3 enable untouched");

        // Enabled event reaches every line
        pulse(5, 5);
        exp_irq(4'b0101, "R7 irq rises");
        exp_rd(A_LSTAT + 8'd0, 32'h20, "R5 line0 status");
        exp_rd(A_LSTAT + 8'd1, 32'h20, "R5 line1 status");
        exp_rd(A_LSTAT + 8'd3, 32'h20, "R5 line3 status");

        // Line acknowledge
        wr(A_LSTAT + 8'd0, 32'h0000_00A0);
        exp_irq(4'b0100, "R7 irq falls after clear");
        exp_rd(A_LSTAT + 8'd0, 32'h0, "R6 line0 cleared");
        exp_rd(A_LSTAT + 8'd2, 32'h20, "R6 line2 kept");

        // Channel flag clear
        exp_rd(A_CSTAT + 8'd5, 32'h28, "R2 ch5 two flags");
        wr(A_CSTAT + 8'd5, 32'h0000_0008);
        exp_rd(A_CSTAT + 8'd5, 32'h20, "R3 partial clear");
        wr(A_CSTAT + 8'd5, 32'h0000_1FFE);
        exp_rd(A_CSTAT + 8'd5, 32'h0, "R3 full clear");

        // Per-flag filtering on channel 7
        wr(A_CEN + 8'd7, 32'h0000_0100);
        pulse(7, 2);
        exp_rd(A_LSTAT + 8'd2, 32'h20, "R4 disabled flag no line set");
        exp_rd(A_CSTAT + 8'd7, 32'h4, "R2 flag recorded regardless");
        pulse(7, 8);
        exp_rd(A_LSTAT + 8'd2, 32'hA0, "R5 enabled error flag");

        // Simultaneous set and clear
        reg_we = 1'b1; reg_addr = A_LSTAT + 8'd2; reg_wdata = 32'h80;
        evt_i[7*FW+8] = 1'b1;
        cyc();
        exp_rd(A_LSTAT + 8'd2, 32'hA0, "R8 line set wins");
        reg_we = 1'b1; reg_addr = A_CSTAT + 8'd7; reg_wdata = 32'h100;
        evt_i[7*FW+8] = 1'b1;
        cyc();
        exp_rd(A_CSTAT + 8'd7, 32'h104, "R8 flag set wins");

        // Outermost channel and highest flag
        wr(A_CEN + 8'd31, 32'h0000_1FFE);
        pulse(31, 12);
        exp_rd(A_CSTAT + 8'd31, 32'h1000, "R2 ch31 drain flag");
        exp_rd(A_LSTAT + 8'd3, 32'h8000_00A0, "R5 line3 bit31");
        wr(A_LEN + 8'd3, 32'h8000_0000);
        exp_irq(4'b1100, "R7 line3 rises on enable");

        // Reserved flag and unmapped addresses
        pulse(3, 0);
        exp_rd(A_CSTAT + 8'd3, 32'h0, "R2 reserved flag ignored");
        exp_rd(8'h20, 32'h0, "R10 unmapped low");
        exp_rd(8'hC0, 32'h0, "R10 unmapped high");

        // Disabling a line drops its output
        wr(A_LEN + 8'd2, 32'h0);
        exp_irq(4'b1000, "R7 line2 falls on disable");

        cyc();
        cyc();
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard leftover got=%0d exp=0", exp_q.size());
        end
        finish_run();
    end
endmodule